// File: doc/BRIEF.md
# Digit-Serial Redundant-Basis Field Multiplier

This block multiplies two binary-field elements held in redundant-basis form. Each element is an N-bit vector in the cyclic ring GF(2)[x]/(x^N - 1), so the product is C = XOR over i of a_i · rotl(B, i), where rotl is a cyclic left rotation by i places within N bits. Because multiplying by x is only a cyclic shift, the block has no modular-reduction logic.

Operand B is loaded with a start pulse and held for the whole operation. Operand A then arrives one D-bit digit per accepted cycle, lowest digit first. A rewiring stage keeps B rotated to match the current digit and hands each of the D partial-product units its own cyclic shift. Each unit ANDs one bit of A with its shifted B. An XOR chain folds the unit outputs together, and an array of one-bit accumulator cells adds the result into the running product. A register between the AND stage and the XOR stage is on by default. With it, the AND step for one digit overlaps the XOR step for the previous digit. When the last digit has drained, the block pulses done, and the product stays on its port until the next start.

Top module: `rb_ds_mult`

## Requirements
- R1: While reset is held and directly after it, prod reads all zeros and done is low.
- R2: After a complete operation, prod equals the XOR over i = 0..N-1 of a_i · rotl(B, i). Digit k carries bits a[kD+D-1:kD], with the LSB of dig_in mapping to a[kD].
- R3: With digits supplied on back-to-back cycles right after start, done rises NDIG + PIPE_AND clock edges after the edge that samples start, where NDIG = ceil(N/D). The value 1 for PIPE_AND places a register between the AND and XOR stages.
- R4: done is high for exactly one cycle per operation, and prod keeps its value from then until the next start.
- R5: An edge that samples start clears the product to zero and discards any operation in progress, including digits still in the pipeline.
- R6: When N is not a multiple of D, bits of the last digit at positions kD+u >= N are treated as zero.
- R7: dig_valid has no effect while no operation is open (before the first start, or after the last digit of an operation), so prod stays unchanged and done stays low.
- R8: When start and dig_valid are both high on one edge, start wins and the digit is dropped.
- R9: Idle cycles between digits (dig_valid low) do not change the product.
- R10: For A with a single set bit i, the product equals B rotated left by i places.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens an operation: loads B, clears the product |
| opb | input | N | Operand B, sampled with start |
| dig_valid | input | 1 | A digit is present on dig_in |
| dig_in | input | D | Next digit of operand A, lowest digit first |
| prod | output | N | Accumulated product in redundant form |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The assertions check the following on every cycle: the one-cycle width of done, that the product is cleared after start, that the product holds while no operation or pipeline slot is active, and that done is never raised while an operation is open. Only the bench scenarios can show the arithmetic and the timing. These cover the full rotate-and-XOR product for swept single-bit and pseudo-random operands, the exact start-to-done edge count, the handling of the padding bits in the last digit, and the results when digits come with gaps, overlap start, or a restart cuts an operation short.

// File: rtl/rb_ds_pkg.sv
package rb_ds_pkg;

   // Number of D-bit digits needed to cover N bits.
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/rb_perm_stage.sv
// Rewiring stage: holds B already rotated for the current digit and hands
// each partial-product unit its own fixed cyclic shift. No gates on the
// shift outputs; the only logic is the register update mux.
module rb_perm_stage #(
   parameter int N = 12,
   parameter int D = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [N-1:0]        b_in,
   input  logic                step,
   output logic [D-1:0][N-1:0] shifts
);
   localparam int SD = D % N;

   logic [N-1:0] base_q;
   logic [N-1:0] base_adv;

   // Rotate left by D places: bit j takes bit (j - D) mod N.
   for (genvar j = 0; j < N; j++) begin : g_adv
      assign base_adv[j] = base_q[(j + N - SD) % N];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    base_q <= '0;
      else if (load) base_q <= b_in;
      else if (step) base_q <= base_adv;
   end

   // Unit u sees the base rotated left by u more places.
   for (genvar u = 0; u < D; u++) begin : g_unit
      for (genvar j = 0; j < N; j++) begin : g_bit
         assign shifts[u][j] = base_q[(j + N - u) % N];
      end
   end
endmodule

// File: rtl/rb_pp_row.sv
// Row of D partial-product units: AND cells, an optional retiming register,
// then an XOR chain. Unit 0 starts the chain and has no XOR.
module rb_pp_row #(
   parameter int N        = 12,
   parameter int D        = 4,
   parameter bit PIPE_AND = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                in_v,
   input  logic                in_last,
   input  logic [D-1:0]        bits,
   input  logic [D-1:0][N-1:0] shifts,
   output logic                out_v,
   output logic                out_last,
   output logic [N-1:0]        sum
);
   logic [D-1:0][N-1:0] and_w;
   logic [D-1:0][N-1:0] and_s;
   logic [D-1:0][N-1:0] chain;

   for (genvar u = 0; u < D; u++) begin : g_and
      assign and_w[u] = shifts[u] & {N{bits[u]}};
   end

   if (PIPE_AND) begin : g_retimed
      logic v_q;
      logic last_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            last_q <= 1'b0;
            and_s  <= '0;
         end else if (clr) begin
            v_q    <= 1'b0;
            last_q <= 1'b0;
         end else begin
            v_q    <= in_v;
            last_q <= in_v & in_last;
            if (in_v) and_s <= and_w;
         end
      end
      assign out_v    = v_q;
      assign out_last = last_q;
   end else begin : g_direct
      assign and_s    = and_w;
      assign out_v    = in_v;
      assign out_last = in_v & in_last;
   end

   assign chain[0] = and_s[0];
   for (genvar u = 1; u < D; u++) begin : g_xor
      assign chain[u] = chain[u-1] ^ and_s[u];
   end
   assign sum = chain[D-1];
endmodule

// File: rtl/rb_accum.sv
// Bank of one-bit accumulation cells plus the completion pulse.
module rb_accum #(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         in_v,
   input  logic         in_last,
   input  logic [N-1:0] sum,
   output logic [N-1:0] acc,
   output logic         done
);
   for (genvar j = 0; j < N; j++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) cell_q <= 1'b0;
         else if (in_v)     cell_q <= cell_q ^ sum[j];
      end
      assign acc[j] = cell_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) done <= 1'b0;
      else        done <= in_v & in_last & ~clr;
   end
endmodule

// File: rtl/rb_ds_mult.sv
module rb_ds_mult #(
   parameter int N        = 12,
   parameter int D        = 4,
   parameter bit PIPE_AND = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [N-1:0] opb,
   input  logic         dig_valid,
   input  logic [D-1:0] dig_in,
   output logic [N-1:0] prod,
   output logic         done
);
   localparam int NDIG = rb_ds_pkg::ceil_div(N, D);
   localparam int CW   = $clog2(NDIG + 1);

   if (N < 2) begin : g_bad_n
      $error("rb_ds_mult: N must be at least 2");
   end
   if (D < 1 || D > N) begin : g_bad_d
      $error("rb_ds_mult: D must lie in 1..N");
   end

   logic                busy;
   logic [CW-1:0]       cnt;
   logic                accept;
   logic                last_dig;
   logic [D-1:0]        dig_mask;
   logic [D-1:0][N-1:0] shifts;
   logic                row_v;
   logic                row_last;
   logic [N-1:0]        row_sum;

   assign accept   = dig_valid & busy & ~start;
   assign last_dig = accept & (cnt == CW'(NDIG - 1));

   // Zero the padding positions of the final digit.
   always_comb begin
      for (int u = 0; u < D; u++) begin
         dig_mask[u] = ((int'(cnt) * D + u) < N);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (accept) begin
         cnt <= cnt + 1'b1;
         if (last_dig) busy <= 1'b0;
      end
   end

   rb_perm_stage #(.N(N), .D(D)) u_perm (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .b_in   (opb),
      .step   (accept),
      .shifts (shifts)
   );

   rb_pp_row #(.N(N), .D(D), .PIPE_AND(PIPE_AND)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .in_v     (accept),
      .in_last  (last_dig),
      .bits     (dig_in & dig_mask),
      .shifts   (shifts),
      .out_v    (row_v),
      .out_last (row_last),
      .sum      (row_sum)
   );

   rb_accum #(.N(N)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .in_v    (row_v),
      .in_last (row_last),
      .sum     (row_sum),
      .acc     (prod),
      .done    (done)
   );
endmodule

// File: rtl/rb_ds_mult_chk.sv
module rb_ds_mult_chk #(
   parameter int N = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         row_v,
   input logic [N-1:0] prod,
   input logic         done
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4

   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (prod == '0)); // R5

   AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(prod)); // R4

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start && !row_v) |=> $stable(prod)); // R7

   AST_NO_DONE_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R3
endmodule

bind rb_ds_mult rb_ds_mult_chk #(.N(N)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .row_v (row_v),
   .prod  (prod),
   .done  (done)
);

// File: tb/sim_rb_ds_mult.sv
`timescale 1ns/1ps
module sim_rb_ds_mult;
   localparam int N    = 10;
   localparam int D    = 4;
   localparam int PIPE = 1;
   localparam int NDIG = (N + D - 1) / D;
   localparam int AW   = NDIG * D;
   localparam int LAT  = NDIG + PIPE + 1; // negedges from start-drive to done seen

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] opb = '0;
   logic         dig_valid = 1'b0;
   logic [D-1:0] dig_in = '0;
   logic [N-1:0] prod;
   logic         done;

   int checks = 0;
   int errors = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   rb_ds_mult #(.N(N), .D(D), .PIPE_AND(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opb(opb),
      .dig_valid(dig_valid), .dig_in(dig_in), .prod(prod), .done(done)
   );

   function automatic logic [N-1:0] model(input logic [N-1:0] b, input logic [AW-1:0] a);
      logic [N-1:0] c = '0;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++)
            c[j] = c[j] ^ (a[i] & b[(j - i + N) % N]);
      return c;
   endfunction

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // One operation; a may carry padding bits above N.
   task automatic run_op(input string req, input logic [N-1:0] b, input logic [AW-1:0] a,
                         input bit gaps, input bit dv_at_start);
      int t = 0;
      int k = 0;
      int done_t = -1;
      logic [N-1:0] got;
      @(negedge clk);
      start = 1'b1; opb = b;
      dig_valid = dv_at_start; dig_in = '1;
      while (t < 40 && done_t < 0) begin
         @(negedge clk);
         t++;
         start = 1'b0;
         if (t == 1) chk("R5 cleared after start", prod, '0);
         if (done) begin done_t = t; got = prod; end
         if (k < NDIG && !(gaps && (t % 2 == 0))) begin
            dig_valid = 1'b1; dig_in = a[k*D +: D]; k++;
         end else begin
            dig_valid = 1'b0; dig_in = '0;
         end
      end
      if (!gaps) chk_int("R3 start-to-done latency", done_t, LAT);
      else       chk_int("R3 done seen", (done_t > 0) ? 1 : 0, 1);
      chk(req, got, model(b, a));
      @(negedge clk);
      chk_int("R4 done one cycle", int'(done), 0);
      chk("R4 product held", prod, got);
   endtask

   initial begin
      logic [N-1:0] b;
      logic [AW-1:0] a;
      logic [N-1:0] held;
      repeat (3) @(negedge clk);
      chk("R1 reset prod", prod, '0);
      chk_int("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 prod after reset", prod, '0);

      // R10: every single-bit A against two B patterns.
      for (int p = 0; p < 2; p++) begin
         b = (p == 0) ? N'(1) : N'(10'h2D3);
         for (int i = 0; i < N; i++) begin
            a = AW'(1) << i;
            run_op("R10 single bit rotation", b, a, 1'b0, 1'b0);
         end
      end

      // R2: pseudo-random sweep, padding bits kept clear.
      for (int n = 0; n < 150; n++) begin
         seed = nxt(seed); b = seed[N-1:0];
         seed = nxt(seed); a = AW'(seed[N-1:0]);
         run_op("R2 random product", b, a, 1'b0, 1'b0);
      end

      // R6: padding bits of the last digit set high.
      for (int n = 0; n < 10; n++) begin
         seed = nxt(seed); b = seed[N-1:0];
         seed = nxt(seed); a = {{(AW-N){1'b1}}, seed[N-1:0]};
         run_op("R6 padding ignored", b, a, 1'b0, 1'b0);
      end

      // R9: idle cycles between digits.
      for (int n = 0; n < 10; n++) begin
         seed = nxt(seed); b = seed[N-1:0];
         seed = nxt(seed); a = AW'(seed[N-1:0]);
         run_op("R9 gapped digits", b, a, 1'b1, 1'b0);
      end

      // R7: digits while no operation is open.
      held = prod;
      @(negedge clk);
      dig_valid = 1'b1; dig_in = '1;
      repeat (3) begin
         @(negedge clk);
         chk("R7 idle digit ignored", prod, held);
         chk_int("R7 no done when idle", int'(done), 0);
      end
      dig_valid = 1'b0;

      // R8: digit on the start edge is dropped.
      for (int n = 0; n < 5; n++) begin
         seed = nxt(seed); b = seed[N-1:0];
         seed = nxt(seed); a = AW'(seed[N-1:0]);
         run_op("R8 start beats digit", b, a, 1'b0, 1'b1);
      end

      // R5: restart in the middle of an operation.
      for (int n = 0; n < 5; n++) begin
         @(negedge clk);
         start = 1'b1; opb = '1;
         @(negedge clk);
         start = 1'b0; dig_valid = 1'b1; dig_in = '1;
         @(negedge clk);
         dig_in = 4'h5;
         seed = nxt(seed); b = seed[N-1:0];
         seed = nxt(seed); a = AW'(seed[N-1:0]);
         run_op("R5 restart discards partial", b, a, 1'b0, 1'b0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule